// File: doc/BRIEF.md
# E1 CRC-4 Interworking and Remote Alarm Controller

This block sits in an E1 framer behind basic frame alignment. It decides what the transmitter sends in the remote alarm (A) bit and in the two E-bits. It also tells the CRC-4 multiframe search and the CRC-4 checker whether to keep running. While CRC-4 multiframe sync is missing, a timer counts basic frames. During that window the remote alarm bit pulses high for one basic frame after every reframe attempt.

When the window expires, a mode bit selects one of two outcomes:
- The block gives up on CRC-4. It flags non-CRC interworking, stops the search and stops CRC error processing, and holds the alarm low.
- The block keeps searching and holds the alarm high until sync arrives.

A force bit overrides the alarm with a fixed level. Once sync is found, the E-bits carry the CRC-4 compare results that were latched per submultiframe. Until then, both E-bits copy a default control bit.

Top module: `crc4_interwork_ctrl`

## Requirements
- R1: After reset, with no sync and the force bit low: txRai is 0, searchEn is 1, nonCrcMode and stopCrcProc are 0, and both E-bits equal cfgEbitDefault.
- R2: While crcSync is 0, txEbit is {cfgEbitDefault, cfgEbitDefault}, for either value of cfgAuto.
- R3: A smfStb with smfIdx=0 latches smfCrcOk for E1 (txEbit[0]). One with smfIdx=1 latches it for E2 (txEbit[1]). A value of 1 means the CRC matched and 0 means it mismatched. The latched pair appears on txEbit only after the next mfStart, and only while crcSync is 1.
- R4: With cfgForceRai=0, no sync and the timer not expired, txRai is high for exactly one basic frame. That frame starts at the first frameStb after a reframeStb. At all other times in this state txRai is low.
- R5: With cfgAuto=0, after TIMEOUT_FRAMES frame strobes without sync, the following hold: nonCrcMode=1, stopCrcProc=1, searchEn=0, txRai=0 (reframe strobes no longer pulse it), and the E-bits equal cfgEbitDefault.
- R6: With cfgAuto=1, after TIMEOUT_FRAMES frame strobes without sync, txRai is held at 1, searchEn stays 1 and nonCrcMode stays 0.
- R7: While crcSync=1 and cfgForceRai=0, txRai is 0 and searchEn is 0.
- R8: While cfgForceRai=1, txRai equals cfgRaiLevel in every state.
- R9: A period with crcSync=1 restarts the timer, so expiry takes a full TIMEOUT_FRAMES frames after sync is lost again.
- R10: A change of cfgAuto restarts the timer and clears nonCrcMode within two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStb | input | 1 | One-cycle pulse per basic frame (8 kHz) |
| reframeStb | input | 1 | One-cycle pulse per reframe attempt |
| crcSync | input | 1 | CRC-4 multiframe sync present |
| smfStb | input | 1 | Submultiframe CRC compare result valid |
| smfIdx | input | 1 | 0 = submultiframe 1, 1 = submultiframe 2 |
| smfCrcOk | input | 1 | 1 = received remainder matched |
| mfStart | input | 1 | Start of an outgoing multiframe; takes up latched results |
| cfgAuto | input | 1 | 0 = fall back to non-CRC on timeout, 1 = keep searching |
| cfgForceRai | input | 1 | Force the alarm bit to cfgRaiLevel |
| cfgRaiLevel | input | 1 | Forced alarm level |
| cfgEbitDefault | input | 1 | E-bit value used without sync |
| txRai | output | 1 | Transmitted remote alarm bit |
| txEbit | output | 2 | Transmitted E-bits, [0]=E1, [1]=E2 |
| nonCrcMode | output | 1 | CRC-to-non-CRC interworking active |
| stopCrcProc | output | 1 | Halt CRC-4 error processing |
| searchEn | output | 1 | Enable the CRC-4 multiframe search |

## Verification
A timer that counts wrongly moves the switch of txRai, nonCrcMode and searchEn by whole frames. So the bench checks those outputs one frame before and exactly at the TIMEOUT_FRAMES-th strobe. A phase that is stuck or stale shows up within two clocks after crcSync or cfgAuto changes, as a wrong alarm level or a wrong search enable. E-bit latching faults show as the wrong bit order, or as a value that appears before mfStart, on the first multiframe after the results arrive.

// File: rtl/crc4iw_pkg.sv
package crc4iw_pkg;

  typedef enum logic [1:0] {
    PH_SYNCED = 2'd0,
    PH_SEARCH = 2'd1,
    PH_GIVEUP = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic   frameTick;
    logic   flickArm;
    phase_e phase;
  } ctrlBus_t;

endpackage

// File: rtl/crc4iw_ctrl.sv
module crc4iw_ctrl
  import crc4iw_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 3200
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStb,
  input  logic     reframeStb,
  input  logic     crcSync,
  input  logic     cfgAuto,
  output ctrlBus_t ctrlBus
);
  localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_FRAMES - 1);

  logic [CNT_W-1:0] cntQ;
  logic             expiredQ;
  logic             autoPrevQ;
  logic             restart;
  phase_e           phase;

  assign restart = crcSync || (cfgAuto != autoPrevQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      expiredQ  <= 1'b0;
      autoPrevQ <= 1'b0;
    end else begin
      autoPrevQ <= cfgAuto;
      if (restart) begin
        cntQ     <= '0;
        expiredQ <= 1'b0;
      end else if (frameStb && !expiredQ) begin
        if (cntQ == LAST) begin
          cntQ     <= '0;
          expiredQ <= 1'b1;
        end else begin
          cntQ <= cntQ + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    if (crcSync)        phase = PH_SYNCED;
    else if (!expiredQ) phase = PH_SEARCH;
    else if (cfgAuto)   phase = PH_HOLD;
    else                phase = PH_GIVEUP;
  end

  assign ctrlBus.frameTick = frameStb;
  assign ctrlBus.flickArm  = reframeStb && (phase == PH_SEARCH);
  assign ctrlBus.phase     = phase;

  // R9: the timer stays below its limit
  a_r9_timer_bounded: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= LAST);
  // R9: a cycle of sync leaves the timer cleared and not expired
  a_r9_sync_restarts: assert property (@(posedge clk) disable iff (!rstN)
    crcSync |=> (cntQ == '0) && !expiredQ);
  // R10: a mode change restarts the timer
  a_r10_mode_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAuto != autoPrevQ) |=> (cntQ == '0) && !expiredQ);
endmodule

// File: rtl/crc4iw_dpath.sv
module crc4iw_dpath
  import crc4iw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrlBus_t   ctrlBus,
  input  logic       smfStb,
  input  logic       smfIdx,
  input  logic       smfCrcOk,
  input  logic       mfStart,
  input  logic       cfgForceRai,
  input  logic       cfgRaiLevel,
  input  logic       cfgEbitDefault,
  output logic       txRai,
  output logic [1:0] txEbit,
  output logic       nonCrcMode,
  output logic       stopCrcProc,
  output logic       searchEn
);
  logic       armPendQ;
  logic       flickQ;
  logic [1:0] errLatchQ;
  logic [1:0] ebitHoldQ;
  logic       inSearch;
  logic       alarmByPhase;

  assign inSearch = (ctrlBus.phase == PH_SEARCH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armPendQ <= 1'b0;
      flickQ   <= 1'b0;
    end else if (!inSearch) begin
      armPendQ <= 1'b0;
      flickQ   <= 1'b0;
    end else if (ctrlBus.frameTick) begin
      flickQ   <= armPendQ;
      armPendQ <= ctrlBus.flickArm;
    end else if (ctrlBus.flickArm) begin
      armPendQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errLatchQ <= 2'b11;
      ebitHoldQ <= 2'b11;
    end else begin
      if (smfStb) errLatchQ[smfIdx] <= smfCrcOk;
      if (mfStart) ebitHoldQ <= errLatchQ;
    end
  end

  always_comb begin
    unique case (ctrlBus.phase)
      PH_SEARCH: alarmByPhase = flickQ;
      PH_HOLD:   alarmByPhase = 1'b1;
      default:   alarmByPhase = 1'b0;
    endcase
  end

  assign txRai       = cfgForceRai ? cfgRaiLevel : alarmByPhase;
  assign txEbit      = (ctrlBus.phase == PH_SYNCED) ? ebitHoldQ
                                                   : {2{cfgEbitDefault}};
  assign nonCrcMode  = (ctrlBus.phase == PH_GIVEUP);
  assign stopCrcProc = nonCrcMode;
  assign searchEn    = inSearch || (ctrlBus.phase == PH_HOLD);

  // R4: a pulse only starts on a frame boundary
  a_r4_pulse_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flickQ) |-> $past(ctrlBus.frameTick));
  // R3: the E-bit hold only changes on a multiframe start
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !mfStart |=> $stable(ebitHoldQ));
endmodule

// File: rtl/crc4_interwork_ctrl.sv
module crc4_interwork_ctrl
  import crc4iw_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 3200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       reframeStb,
  input  logic       crcSync,
  input  logic       smfStb,
  input  logic       smfIdx,
  input  logic       smfCrcOk,
  input  logic       mfStart,
  input  logic       cfgAuto,
  input  logic       cfgForceRai,
  input  logic       cfgRaiLevel,
  input  logic       cfgEbitDefault,
  output logic       txRai,
  output logic [1:0] txEbit,
  output logic       nonCrcMode,
  output logic       stopCrcProc,
  output logic       searchEn
);
  ctrlBus_t ctrlBus;

  crc4iw_ctrl #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .reframeStb(reframeStb),
    .crcSync(crcSync), .cfgAuto(cfgAuto), .ctrlBus(ctrlBus)
  );

  crc4iw_dpath dpath_i (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .smfStb(smfStb),
    .smfIdx(smfIdx), .smfCrcOk(smfCrcOk), .mfStart(mfStart),
    .cfgForceRai(cfgForceRai), .cfgRaiLevel(cfgRaiLevel),
    .cfgEbitDefault(cfgEbitDefault), .txRai(txRai), .txEbit(txEbit),
    .nonCrcMode(nonCrcMode), .stopCrcProc(stopCrcProc), .searchEn(searchEn)
  );

  // R5: fallback stops the search and the CRC processing together
  a_r5_fallback_outputs: assert property (@(posedge clk) disable iff (!rstN)
    nonCrcMode |-> !searchEn && stopCrcProc);
  // R7: with sync and no force, the alarm is low and the search is off
  a_r7_synced_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (crcSync && !cfgForceRai) |-> !txRai && !searchEn);
endmodule

// File: tb/crc4_interwork_ctrl_tb.sv
module crc4_interwork_ctrl_tb_top;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStb = 0, reframeStb = 0, crcSync = 0, smfStb = 0, smfIdx = 0;
  logic smfCrcOk = 0, mfStart = 0, cfgAuto = 0, cfgForceRai = 0;
  logic cfgRaiLevel = 0, cfgEbitDefault = 1;
  logic txRai, nonCrcMode, stopCrcProc, searchEn;
  logic [1:0] txEbit;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crc4_interwork_ctrl #(.TIMEOUT_FRAMES(TO)) dut_i (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .reframeStb(reframeStb),
    .crcSync(crcSync), .smfStb(smfStb), .smfIdx(smfIdx), .smfCrcOk(smfCrcOk),
    .mfStart(mfStart), .cfgAuto(cfgAuto), .cfgForceRai(cfgForceRai),
    .cfgRaiLevel(cfgRaiLevel), .cfgEbitDefault(cfgEbitDefault),
    .txRai(txRai), .txEbit(txEbit), .nonCrcMode(nonCrcMode),
    .stopCrcProc(stopCrcProc), .searchEn(searchEn)
  );

  // [8]auto [7]force [6]level [5]ebitDefault [4]sync [3]expRai [2:1]expEbit [0]expSearch
  localparam logic [8:0] VEC [8] = '{
    9'b0_0_0_0_0_0_00_1, 9'b0_0_0_1_0_0_11_1, 9'b1_0_0_1_0_0_11_1,
    9'b0_1_1_0_0_1_00_1, 9'b1_1_1_1_0_1_11_1, 9'b1_1_0_0_1_0_11_0,
    9'b0_0_0_0_1_0_11_0, 9'b0_1_1_0_1_1_11_0
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame();
    frameStb = 1; @(negedge clk); frameStb = 0; idle(3);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) frame();
  endtask

  task automatic pulse_sync();
    crcSync = 1; idle(2); crcSync = 0; idle(1);
  endtask

  task automatic reframe();
    reframeStb = 1; @(negedge clk); reframeStb = 0; idle(1);
  endtask

  task automatic smf(input logic idx, input logic ok);
    smfIdx = idx; smfCrcOk = ok; smfStb = 1; @(negedge clk); smfStb = 0; idle(1);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    idle(3); rstN = 1; idle(1);
    // R1 reset state
    chk("R1 rai", txRai, 0);
    chk("R1 ebit", txEbit, 2'b11);
    chk("R1 search", searchEn, 1);
    chk("R1 noncrc/stop", {nonCrcMode, stopCrcProc}, 2'b00);

    // Table: static levels (R2, R7, R8)
    for (int v = 0; v < 8; v++) begin
      {cfgAuto, cfgForceRai, cfgRaiLevel, cfgEbitDefault, crcSync} = VEC[v][8:4];
      idle(2);
      chk("R8/R7 rai table", txRai, VEC[v][3]);
      chk("R2/R3 ebit table", txEbit, VEC[v][2:1]);
      chk("R7 search table", searchEn, VEC[v][0]);
    end

    // R4 flicker
    cfgAuto = 0; cfgForceRai = 0; cfgEbitDefault = 0; crcSync = 0; idle(2);
    pulse_sync();
    reframe();
    chk("R4 no pulse before frame", txRai, 0);
    frame();
    chk("R4 pulse high", txRai, 1);
    frame();
    chk("R4 pulse one frame", txRai, 0);

    // R5 fallback (2 frames used so far)
    frames(TO - 3);
    chk("R5 before expiry", {nonCrcMode, searchEn}, 2'b01);
    frame();
    chk("R5 noncrc/stop", {nonCrcMode, stopCrcProc}, 2'b11);
    chk("R5 search off", searchEn, 0);
    chk("R2 ebit default", txEbit, 2'b00);
    reframe(); frame();
    chk("R5 rai stays low", txRai, 0);

    // R10 mode change restarts
    cfgAuto = 1; idle(2);
    chk("R10 noncrc cleared", {nonCrcMode, searchEn}, 2'b01);
    frames(TO - 1);
    chk("R6 not yet held", txRai, 0);
    frame();
    chk("R6 rai held high", txRai, 1);
    chk("R6 search on", {searchEn, nonCrcMode}, 2'b10);
    frames(3);
    chk("R6 rai continuous", txRai, 1);

    // R8 force over held state
    cfgForceRai = 1; cfgRaiLevel = 0; idle(1);
    chk("R8 force low", txRai, 0);
    cfgRaiLevel = 1; idle(1);
    chk("R8 force high", txRai, 1);
    cfgForceRai = 0;

    // R7 sync achieved
    crcSync = 1; idle(2);
    chk("R7 rai low", txRai, 0);
    chk("R7 search off", searchEn, 0);

    // R3 E-bit ordering and latching
    smf(0, 0); smf(1, 1);
    chk("R3 held before mfStart", txEbit, 2'b11);
    mfStart = 1; @(negedge clk); mfStart = 0; idle(1);
    chk("R3 E1=0 E2=1", txEbit, 2'b10);
    smf(0, 1); smf(1, 0);
    mfStart = 1; @(negedge clk); mfStart = 0; idle(1);
    chk("R3 E1=1 E2=0", txEbit, 2'b01);

    // R9 sync loss restarts timer
    crcSync = 0; idle(1);
    frames(10);
    pulse_sync();
    frames(TO - 1);
    chk("R9 restarted, not expired", txRai, 0);
    frame();
    chk("R9 expiry after full window", txRai, 1);

    finished = 1;
    report();
  end
endmodule